// File: doc/BRIEF.md
# Backplane Core Reset and Disable Sequencer

This block carries out, in hardware, the two bring-up procedures for a single core on an on-chip backplane. One takes the core out of service cleanly. The other takes it out of service and then brings it back up with its clocks running. The block is a master on a simple 32-bit register bus with 12-bit offsets. Through that bus it reads and writes four registers of the core:

- target low control at 0xF98
- target high status at 0xF9C
- initiator status at 0xF90
- identification low at 0xFF8

A command carries three things: an enable/disable select, twelve core-specific flag bits and a revision select. The revision select moves the position of the target reject bit.

Each procedure follows a fixed ordered handshake:

1. New transactions are refused.
2. The block waits for target busy and initiator busy to drain.
3. Reset is applied with the gated clocks forced on.
4. Sticky error bits are cleared.
5. Reset is released, and then the clock force is dropped.

Every control write is followed by a dummy read and a timed settle delay. The settle delays come from a counter whose cycles-per-microsecond value is a parameter. Each polling loop has a limit on the number of reads it makes. If a loop reaches that limit, the block raises a sticky timeout error and abandons the procedure.

Top module: `core_reset_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout_err` and `bus_req` are all 0.
- R2: A bus request holds `bus_addr`, `bus_we` and `bus_wdata` steady until the cycle in which `bus_ack` is seen. Only one transfer is outstanding at a time. Addresses are limited to 0xF98, 0xF9C, 0xF90 and 0xFF8.
- R3: A command (`cmd_valid` high) is taken only while `busy` is low. A command presented while busy causes no bus activity, either during the procedure or after it.
- R4: Disable first reads 0xF98. If bit 0 (reset) of that value is set, the disable part makes no further bus access.
- R5: If bit 16 (clock enable) of the value read from 0xF98 is set, the block writes that value back with the reject bit also set. The reject bit is bit 1 when `rev_new`=0 and bit 2 when `rev_new`=1. The block then does a dummy read of 0xF98, waits 1 us, and reads 0xF9C until its bit 2 (busy) is clear. After that it reads 0xFF8.
- R6: If bit 7 of 0xFF8 is set, the block performs the following steps in order:
  - read 0xF90 and write it back with bit 25 set;
  - dummy-read 0xF90 and wait 1 us;
  - poll 0xF90 until bits 24:23 read zero;
  - after the 10 us hold described in R7, read 0xF90 and write it back with bit 25 cleared.
- R7: In the clock-enabled path, the block writes 0xF98 = {flags,2'b11}<<16 | 3, does a dummy read and waits 10 us. Disable always ends with a write of 0xF98 = flags<<18 | 3 and a 1 us wait. When clock enable was clear, that final write is the only write.
- R8: Enable runs the disable procedure first. It then performs the following steps in order:
  - write 0xF98 = flags<<18 | bit17 | bit16 | bit0, dummy-read 0xF98, wait 1 us;
  - handle the error checks of R9;
  - write flags<<18 | bit17 | bit16, dummy-read 0xF98, wait 1 us;
  - write flags<<18 | bit16, wait 1 us.
- R9: During enable, the block reads 0xF9C and writes it to zero only if bit 0 is set. It then reads 0xF90 and writes it back with bits 17 and 18 cleared only if either of those bits is set.
- R10: A 1 us wait lasts CYC_PER_US clock cycles and a 10 us wait lasts 10*CYC_PER_US cycles. The block makes no bus access during a wait.
- R11: A polling loop that makes POLL_MAX reads, all of them busy, sets `timeout_err` and ends the procedure with no further bus access. `timeout_err` then stays set until reset.
- R12: `busy` is high from the cycle after a command is taken until the end of the procedure. `done` pulses for exactly one cycle, in the cycle where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken while idle |
| cmd_enable | input | 1 | 1 = full enable procedure, 0 = disable only |
| cmd_flags | input | 12 | Core-specific flags, placed at bits 29:18 of 0xF98 |
| rev_new | input | 1 | 1 = reject at bit 2, 0 = reject at bit 1 |
| busy | output | 1 | Procedure in progress |
| done | output | 1 | One-cycle end-of-procedure pulse |
| timeout_err | output | 1 | Sticky polling-limit error |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | Register offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer complete, read data valid |
| bus_rdata | input | 32 | Read data |

## Verification
A wrong step state shows at once on the bus as a transfer with the wrong offset, direction or data. Comparing the full ordered transfer log against the sequence built from the requirements catches it within the same procedure. A wrong delay counter shows as a gap between a settle read and the following request that is too short or too long. A polling or decision error shows either as a wrong number of status reads, or as a missing or extra conditional write (reject set or clear, error clears). A stuck completion path shows as a `done` pulse that is late, missing or longer than one cycle.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int FW = 12;

  localparam logic [AW-1:0] A_TGT_LO = 12'hF98;
  localparam logic [AW-1:0] A_TGT_HI = 12'hF9C;
  localparam logic [AW-1:0] A_INI_ST = 12'hF90;
  localparam logic [AW-1:0] A_CID_LO = 12'hFF8;

  localparam logic [DW-1:0] LO_RST    = 32'h0000_0001;
  localparam logic [DW-1:0] LO_CLKEN  = 32'h0001_0000;
  localparam logic [DW-1:0] LO_FORCE  = 32'h0002_0000;
  localparam logic [DW-1:0] INI_REJ   = 32'h0200_0000;
  localparam logic [DW-1:0] INI_BUSY  = 32'h0180_0000;
  localparam logic [DW-1:0] INI_ERRS  = 32'h0006_0000;

  typedef enum logic [2:0] {K_NONE, K_RD, K_WR, K_WAIT1, K_WAIT10} step_kind_t;

  typedef enum logic [4:0] {
    S_IDLE, S_FINISH,
    S_D_RD_LO, S_D_SET_REJ, S_D_DUM_LO1, S_D_DLY_A, S_D_POLL_HI, S_D_RD_ID,
    S_D_RD_IN, S_D_SET_IREJ, S_D_DUM_IN, S_D_DLY_B, S_D_POLL_IN,
    S_D_WR_HOLD, S_D_DUM_LO2, S_D_DLY_C, S_D_RD_IN2, S_D_CLR_IREJ,
    S_D_WR_FIN, S_D_DLY_D,
    S_E_WR_RST, S_E_DUM1, S_E_DLY1, S_E_RD_HI, S_E_CLR_HI, S_E_RD_IN,
    S_E_CLR_IN, S_E_WR_CLK, S_E_DUM2, S_E_DLY2, S_E_WR_CE, S_E_DLY3
  } seq_state_t;

  function automatic logic [DW-1:0] flag_word(input logic [FW-1:0] f);
    return {2'b00, f, 18'b0};
  endfunction
endpackage

// File: rtl/seq_delay.sv
module seq_delay #(
  parameter int CYC_PER_US = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_wait,
  output logic done
);
  localparam int LMAX = 10 * CYC_PER_US;
  localparam int CW   = $clog2(LMAX + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run <= 1'b1;
        cnt <= long_wait ? CW'(LMAX - 1) : CW'(CYC_PER_US - 1);
      end else if (run) begin
        if (cnt == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/seq_bus_port.sv
module seq_bus_port
  import core_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          xfer_done,
  output logic [DW-1:0] rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rdata     <= '0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req   <= 1'b0;
          xfer_done <= 1'b1;
          if (!bus_we) rdata <= bus_rdata;
        end
      end else if (start) begin
        bus_req   <= 1'b1;
        bus_we    <= we;
        bus_addr  <= addr;
        bus_wdata <= wdata;
      end
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import core_seq_pkg::*;
#(
  parameter int POLL_MAX = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_enable,
  input  logic [FW-1:0] cmd_flags,
  input  logic          rev_new,
  output logic          busy,
  output logic          done,
  output logic          timeout_err,
  output logic          bus_start,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_done,
  input  logic [DW-1:0] bus_rdata,
  output logic          tmr_start,
  output logic          tmr_long,
  input  logic          tmr_done
);
  localparam int PW = $clog2(POLL_MAX + 1);

  seq_state_t    st, nxt;
  step_kind_t    kind;
  logic          pend;
  logic          en_q, rev_q, init_q, tmo;
  logic [FW-1:0] flags_q;
  logic [PW-1:0] pcnt;
  logic [DW-1:0] fw, rej;
  seq_state_t    after_dis;
  logic          poll_last;

  assign fw        = flag_word(flags_q);
  assign rej       = rev_q ? 32'h4 : 32'h2;
  assign after_dis = en_q ? S_E_WR_RST : S_FINISH;
  assign poll_last = (pcnt == PW'(POLL_MAX - 1));

  always_comb begin
    kind        = K_NONE;
    bus_addr_o  = A_TGT_LO;
    bus_wdata_o = '0;
    nxt         = st;
    tmo         = 1'b0;
    case (st)
      S_D_RD_LO: begin
        kind = K_RD;
        if (bus_rdata[0])       nxt = after_dis;
        else if (bus_rdata[16]) nxt = S_D_SET_REJ;
        else                    nxt = S_D_WR_FIN;
      end
      S_D_SET_REJ: begin kind = K_WR; bus_wdata_o = bus_rdata | rej; nxt = S_D_DUM_LO1; end
      S_D_DUM_LO1: begin kind = K_RD; nxt = S_D_DLY_A; end
      S_D_DLY_A:   begin kind = K_WAIT1; nxt = S_D_POLL_HI; end
      S_D_POLL_HI: begin
        kind = K_RD; bus_addr_o = A_TGT_HI;
        if (!bus_rdata[2])  nxt = S_D_RD_ID;
        else if (poll_last) begin nxt = S_FINISH; tmo = 1'b1; end
      end
      S_D_RD_ID: begin
        kind = K_RD; bus_addr_o = A_CID_LO;
        nxt = bus_rdata[7] ? S_D_RD_IN : S_D_WR_HOLD;
      end
      S_D_RD_IN:    begin kind = K_RD; bus_addr_o = A_INI_ST; nxt = S_D_SET_IREJ; end
      S_D_SET_IREJ: begin
        kind = K_WR; bus_addr_o = A_INI_ST; bus_wdata_o = bus_rdata | INI_REJ;
        nxt = S_D_DUM_IN;
      end
      S_D_DUM_IN:  begin kind = K_RD; bus_addr_o = A_INI_ST; nxt = S_D_DLY_B; end
      S_D_DLY_B:   begin kind = K_WAIT1; nxt = S_D_POLL_IN; end
      S_D_POLL_IN: begin
        kind = K_RD; bus_addr_o = A_INI_ST;
        if ((bus_rdata & INI_BUSY) == '0) nxt = S_D_WR_HOLD;
        else if (poll_last) begin nxt = S_FINISH; tmo = 1'b1; end
      end
      S_D_WR_HOLD: begin
        kind = K_WR; bus_wdata_o = fw | LO_FORCE | LO_CLKEN | 32'h3;
        nxt = S_D_DUM_LO2;
      end
      S_D_DUM_LO2: begin kind = K_RD; nxt = S_D_DLY_C; end
      S_D_DLY_C:   begin kind = K_WAIT10; nxt = init_q ? S_D_RD_IN2 : S_D_WR_FIN; end
      S_D_RD_IN2:  begin kind = K_RD; bus_addr_o = A_INI_ST; nxt = S_D_CLR_IREJ; end
      S_D_CLR_IREJ: begin
        kind = K_WR; bus_addr_o = A_INI_ST; bus_wdata_o = bus_rdata & ~INI_REJ;
        nxt = S_D_WR_FIN;
      end
      S_D_WR_FIN: begin kind = K_WR; bus_wdata_o = fw | 32'h3; nxt = S_D_DLY_D; end
      S_D_DLY_D:  begin kind = K_WAIT1; nxt = after_dis; end
      S_E_WR_RST: begin
        kind = K_WR; bus_wdata_o = fw | LO_FORCE | LO_CLKEN | LO_RST;
        nxt = S_E_DUM1;
      end
      S_E_DUM1:  begin kind = K_RD; nxt = S_E_DLY1; end
      S_E_DLY1:  begin kind = K_WAIT1; nxt = S_E_RD_HI; end
      S_E_RD_HI: begin
        kind = K_RD; bus_addr_o = A_TGT_HI;
        nxt = bus_rdata[0] ? S_E_CLR_HI : S_E_RD_IN;
      end
      S_E_CLR_HI: begin kind = K_WR; bus_addr_o = A_TGT_HI; nxt = S_E_RD_IN; end
      S_E_RD_IN: begin
        kind = K_RD; bus_addr_o = A_INI_ST;
        nxt = ((bus_rdata & INI_ERRS) != '0) ? S_E_CLR_IN : S_E_WR_CLK;
      end
      S_E_CLR_IN: begin
        kind = K_WR; bus_addr_o = A_INI_ST; bus_wdata_o = bus_rdata & ~INI_ERRS;
        nxt = S_E_WR_CLK;
      end
      S_E_WR_CLK: begin kind = K_WR; bus_wdata_o = fw | LO_FORCE | LO_CLKEN; nxt = S_E_DUM2; end
      S_E_DUM2:   begin kind = K_RD; nxt = S_E_DLY2; end
      S_E_DLY2:   begin kind = K_WAIT1; nxt = S_E_WR_CE; end
      S_E_WR_CE:  begin kind = K_WR; bus_wdata_o = fw | LO_CLKEN; nxt = S_E_DLY3; end
      S_E_DLY3:   begin kind = K_WAIT1; nxt = S_FINISH; end
      default: ;
    endcase
  end

  assign bus_we_o  = (kind == K_WR);
  assign bus_start = !pend && (kind == K_RD || kind == K_WR);
  assign tmr_start = !pend && (kind == K_WAIT1 || kind == K_WAIT10);
  assign tmr_long  = (kind == K_WAIT10);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      pend        <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      en_q        <= 1'b0;
      rev_q       <= 1'b0;
      init_q      <= 1'b0;
      flags_q     <= '0;
      pcnt        <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          en_q    <= cmd_enable;
          rev_q   <= rev_new;
          flags_q <= cmd_flags;
          init_q  <= 1'b0;
          pcnt    <= '0;
          pend    <= 1'b0;
          busy    <= 1'b1;
          st      <= S_D_RD_LO;
        end
        S_FINISH: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: begin
          if (!pend) begin
            pend <= 1'b1;
          end else if (bus_done || tmr_done) begin
            pend <= 1'b0;
            st   <= nxt;
            pcnt <= (nxt == st) ? pcnt + 1'b1 : '0;
            if (tmo) timeout_err <= 1'b1;
            if (st == S_D_RD_ID) init_q <= bus_rdata[7];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/core_reset_seq.sv
module core_reset_seq
  import core_seq_pkg::*;
#(
  parameter int CYC_PER_US = 250,
  parameter int POLL_MAX   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_enable,
  input  logic [FW-1:0] cmd_flags,
  input  logic          rev_new,
  output logic          busy,
  output logic          done,
  output logic          timeout_err,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);
  logic          b_start, b_we, b_done, t_start, t_long, t_done;
  logic [AW-1:0] b_addr;
  logic [DW-1:0] b_wdata, b_rdata;

  seq_ctrl #(.POLL_MAX(POLL_MAX)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_enable(cmd_enable),
    .cmd_flags(cmd_flags), .rev_new(rev_new), .busy(busy), .done(done),
    .timeout_err(timeout_err), .bus_start(b_start), .bus_we_o(b_we),
    .bus_addr_o(b_addr), .bus_wdata_o(b_wdata), .bus_done(b_done),
    .bus_rdata(b_rdata), .tmr_start(t_start), .tmr_long(t_long), .tmr_done(t_done)
  );

  seq_bus_port u_bus (
    .clk(clk), .rst(rst), .start(b_start), .we(b_we), .addr(b_addr),
    .wdata(b_wdata), .xfer_done(b_done), .rdata(b_rdata), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  seq_delay #(.CYC_PER_US(CYC_PER_US)) u_dly (
    .clk(clk), .rst(rst), .start(t_start), .long_wait(t_long), .done(t_done)
  );
endmodule

// File: rtl/core_reset_seq_chk.sv
module core_reset_seq_chk
  import core_seq_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          busy,
  input logic          done,
  input logic          timeout_err,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R2
  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_addr == A_TGT_LO || bus_addr == A_TGT_HI || bus_addr == A_INI_ST || bus_addr == A_CID_LO)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req); // R3
  AST_TAKE_CMD: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_valid) |=> busy); // R3
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> timeout_err); // R11
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |=> done); // R11
endmodule

bind core_reset_seq core_reset_seq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .timeout_err(timeout_err), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/tb_core_reset_seq.sv
`timescale 1ns/1ps
module tb_core_reset_seq;
  localparam int CYC  = 5;
  localparam int PMAX = 8;
  localparam logic [11:0] A_LO = 12'hF98, A_HI = 12'hF9C, A_IN = 12'hF90, A_ID = 12'hFF8;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_enable = 0, rev_new = 0;
  logic [11:0] cmd_flags = '0;
  logic busy, done, timeout_err, bus_req, bus_we, bus_ack;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  core_reset_seq #(.CYC_PER_US(CYC), .POLL_MAX(PMAX)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_enable(cmd_enable),
    .cmd_flags(cmd_flags), .rev_new(rev_new), .busy(busy), .done(done),
    .timeout_err(timeout_err), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit ended = 0;

  // register model and transfer log
  logic [31:0] r_lo, r_hi, r_in, r_id;
  int hi_busy, in_busy, lat, viol, cyc;
  int n_log, n_exp;
  logic        lg_we[64], ex_we[64];
  logic [11:0] lg_ad[64], ex_ad[64];
  logic [31:0] lg_d[64],  ex_d[64];
  int          lg_t[64];
  bit          sp;
  int          wc;
  logic        c_we;
  logic [11:0] c_ad;
  logic [31:0] c_d;

  initial begin
    r_lo = 0; r_hi = 0; r_in = 0; r_id = 0; hi_busy = 0; in_busy = 0;
    lat = 0; viol = 0; cyc = 0; n_log = 0; n_exp = 0; sp = 0; wc = 0;
    bus_ack = 0; bus_rdata = 0;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      bus_ack <= 0; sp = 0;
    end else if (bus_req && !bus_ack) begin
      if (!sp) begin
        sp = 1; c_we = bus_we; c_ad = bus_addr; c_d = bus_wdata; wc = lat;
      end else if (c_we != bus_we || c_ad != bus_addr || c_d != bus_wdata) viol = viol + 1;
      if (wc == 0) begin
        sp = 0;
        bus_ack <= 1;
        if (n_log < 64) begin
          lg_we[n_log] = c_we; lg_ad[n_log] = c_ad; lg_d[n_log] = c_d; lg_t[n_log] = cyc;
        end
        n_log = n_log + 1;
        if (c_we) begin
          case (c_ad)
            A_LO: r_lo = c_d;
            A_HI: r_hi = c_d & ~32'h4;
            A_IN: r_in = c_d & ~32'h0180_0000;
            default: ;
          endcase
        end else begin
          case (c_ad)
            A_LO: bus_rdata <= r_lo;
            A_HI: begin bus_rdata <= r_hi | (hi_busy > 0 ? 32'h4 : 32'h0);
                        if (hi_busy > 0) hi_busy = hi_busy - 1; end
            A_IN: begin bus_rdata <= r_in | (in_busy > 0 ? 32'h0180_0000 : 32'h0);
                        if (in_busy > 0) in_busy = in_busy - 1; end
            A_ID: bus_rdata <= r_id;
            default: bus_rdata <= 32'hDEAD_BEEF;
          endcase
        end
      end else wc = wc - 1;
    end else bus_ack <= 0;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic logic [31:0] fw(input logic [11:0] f);
    return {2'b00, f, 18'b0};
  endfunction

  task automatic ex(input logic we, input logic [11:0] ad, input logic [31:0] d);
    ex_we[n_exp] = we; ex_ad[n_exp] = ad; ex_d[n_exp] = d; n_exp++;
  endtask

  task automatic cmp_log(input string req);
    int bad = -1;
    chk(n_log == n_exp, req, "transfer count", n_log, n_exp);
    if (n_log == n_exp)
      for (int i = 0; i < n_exp; i++)
        if (bad < 0 && (lg_we[i] != ex_we[i] || lg_ad[i] != ex_ad[i] || (ex_we[i] && lg_d[i] != ex_d[i])))
          bad = i;
    if (n_log == n_exp) begin
      if (bad >= 0)
        chk(0, req, $sformatf("transfer %0d we/addr/data", bad),
            {lg_we[bad], lg_ad[bad], lg_d[bad]}, {ex_we[bad], ex_ad[bad], ex_d[bad]});
      else chk(1, req, "sequence", 0, 0);
    end
  endtask

  task automatic start_cmd(input logic en, input logic [11:0] f, input logic rv);
    n_log = 0; n_exp = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_enable = en; cmd_flags = f; rev_new = rv;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 50000) begin @(negedge clk); k++; end
    chk(done == 1, req, "done seen", done, 1);
    chk(busy == 0, "R12", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 0, "R12", "done one cycle", done, 0);
  endtask

  // R1
  task automatic t_reset();
    chk(busy == 0 && done == 0 && timeout_err == 0 && bus_req == 0, "R1", "reset outputs",
        {busy, done, timeout_err, bus_req}, 0);
  endtask

  // R4: reset bit already set
  task automatic t_dis_in_reset();
    r_lo = 32'h0001_0001;
    start_cmd(0, 12'h123, 1);
    ex(0, A_LO, 0);
    wait_done("R4");
    cmp_log("R4");
    chk(r_lo == 32'h0001_0001, "R4", "state low untouched", r_lo, 32'h0001_0001);
  endtask

  // R7: clock disabled path
  task automatic t_dis_clk_off();
    logic [11:0] f = 12'hA5C;
    r_lo = 32'h0;
    start_cmd(0, f, 1);
    ex(0, A_LO, 0); ex(1, A_LO, fw(f) | 32'h3);
    wait_done("R7");
    cmp_log("R7");
  endtask

  // R5, R7, R10, R2 with wait states: rev 2.3 reject, target busy twice
  task automatic t_dis_full_new();
    logic [11:0] f = 12'h3F1;
    logic [31:0] v = 32'h00C1_0000;
    r_lo = v; hi_busy = 2; r_id = 32'h0; lat = 3; viol = 0;
    start_cmd(0, f, 1);
    ex(0, A_LO, 0); ex(1, A_LO, v | 32'h4); ex(0, A_LO, 0);
    ex(0, A_HI, 0); ex(0, A_HI, 0); ex(0, A_HI, 0);
    ex(0, A_ID, 0);
    ex(1, A_LO, fw(f) | 32'h0003_0003); ex(0, A_LO, 0);
    ex(1, A_LO, fw(f) | 32'h3);
    wait_done("R5");
    cmp_log("R5");
    chk(viol == 0, "R2", "request changed while waiting", viol, 0);
    if (n_log == 10) begin
      chk(lg_t[3] - lg_t[2] >= CYC && lg_t[3] - lg_t[2] <= CYC + 12, "R10", "1us gap",
          lg_t[3] - lg_t[2], CYC);
      chk(lg_t[9] - lg_t[8] >= 10*CYC && lg_t[9] - lg_t[8] <= 10*CYC + 12, "R10", "10us gap",
          lg_t[9] - lg_t[8], 10*CYC);
    end
    chk(r_lo == (fw(f) | 32'h3), "R7", "final state low", r_lo, fw(f) | 32'h3);
    lat = 0;
  endtask

  // R6, R5 (rev 2.2 reject bit 1)
  task automatic t_dis_init_old();
    logic [11:0] f = 12'h001;
    r_lo = 32'h0003_0000; hi_busy = 0; r_id = 32'h80; r_in = 32'h30; in_busy = 3;
    start_cmd(0, f, 0);
    ex(0, A_LO, 0); ex(1, A_LO, 32'h0003_0002); ex(0, A_LO, 0);
    ex(0, A_HI, 0); ex(0, A_ID, 0);
    ex(0, A_IN, 0); ex(1, A_IN, 32'h0380_0030); ex(0, A_IN, 0);
    ex(0, A_IN, 0); ex(0, A_IN, 0);
    ex(1, A_LO, fw(f) | 32'h0003_0003); ex(0, A_LO, 0);
    ex(0, A_IN, 0); ex(1, A_IN, 32'h30);
    ex(1, A_LO, fw(f) | 32'h3);
    wait_done("R6");
    cmp_log("R6");
    chk(r_in == 32'h30, "R6", "initiator reject cleared", r_in, 32'h30);
    r_id = 0;
  endtask

  // R8, R9 with both error clears
  task automatic t_enable_err();
    logic [11:0] f = 12'hA5C;
    r_lo = 32'h1; r_hi = 32'h1; r_in = 32'h0006_0030;
    start_cmd(1, f, 1);
    ex(0, A_LO, 0);
    ex(1, A_LO, fw(f) | 32'h0003_0001); ex(0, A_LO, 0);
    ex(0, A_HI, 0); ex(1, A_HI, 32'h0);
    ex(0, A_IN, 0); ex(1, A_IN, 32'h30);
    ex(1, A_LO, fw(f) | 32'h0003_0000); ex(0, A_LO, 0);
    ex(1, A_LO, fw(f) | 32'h0001_0000);
    wait_done("R8");
    cmp_log("R9");
    chk(r_lo == (fw(f) | 32'h0001_0000), "R8", "final state low", r_lo, fw(f) | 32'h0001_0000);
  endtask

  // R8, R9 no errors: no clearing writes
  task automatic t_enable_clean();
    logic [11:0] f = 12'h800;
    r_lo = 32'h0; r_hi = 32'h0; r_in = 32'h30;
    start_cmd(1, f, 0);
    ex(0, A_LO, 0); ex(1, A_LO, fw(f) | 32'h3);
    ex(1, A_LO, fw(f) | 32'h0003_0001); ex(0, A_LO, 0);
    ex(0, A_HI, 0); ex(0, A_IN, 0);
    ex(1, A_LO, fw(f) | 32'h0003_0000); ex(0, A_LO, 0);
    ex(1, A_LO, fw(f) | 32'h0001_0000);
    wait_done("R8");
    cmp_log("R9");
  endtask

  // R11 timeout and stickiness
  task automatic t_timeout();
    r_lo = 32'h0001_0000; hi_busy = 1000;
    start_cmd(1, 12'h0, 1);
    ex(0, A_LO, 0); ex(1, A_LO, 32'h0001_0004); ex(0, A_LO, 0);
    for (int i = 0; i < PMAX; i++) ex(0, A_HI, 0);
    wait_done("R11");
    cmp_log("R11");
    chk(timeout_err == 1, "R11", "timeout flag", timeout_err, 1);
    chk(r_lo == 32'h0001_0004, "R11", "no write after timeout", r_lo, 32'h0001_0004);
    hi_busy = 0;
    r_lo = 32'h1;
    start_cmd(0, 12'h0, 1);
    wait_done("R11");
    chk(timeout_err == 1, "R11", "flag sticky", timeout_err, 1);
  endtask

  // R3 command during busy ignored
  task automatic t_busy_ignore();
    int nl;
    r_lo = 32'h0; hi_busy = 0;
    start_cmd(0, 12'h0, 1);
    repeat (3) @(negedge clk);
    chk(busy == 1, "R12", "busy during procedure", busy, 1);
    cmd_valid = 1; cmd_enable = 1;
    @(negedge clk);
    cmd_valid = 0; cmd_enable = 0;
    wait_done("R3");
    nl = n_log;
    repeat (40) begin
      @(negedge clk);
      if (bus_req || busy) nl = -1;
    end
    chk(nl == 2 && n_log == 2, "R3", "transfers for ignored command", n_log, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_dis_in_reset();
    t_dis_clk_off();
    t_dis_full_new();
    t_dis_init_old();
    t_enable_err();
    t_enable_clean();
    t_busy_ignore();
    t_timeout();
    repeat (5) @(negedge clk);
    summary();
  end
endmodule